// File: doc/BRIEF.md
# Serial EEPROM Station Address Reader

This block reads a 48-bit station address out of a three-wire serial EEPROM by driving its pins directly. One request starts three single-word reads in a fixed order: the low word, then the middle word, then the high word. Each read raises chip select and sends a 9-bit command, made of a 3-bit read opcode followed by a 6-bit word address. It then clocks in 16 data bits and ends with one more clock pulse after chip select has dropped.

Pin timing comes from a tick divider. The divider is sized from the system clock rate and a tick period. The serial clock stays high for a set number of ticks and low for a shorter set number, so the high and low times are not equal. When the third word arrives, the three words are put together into the address in byte-reversed order. The result is presented with a one-cycle valid pulse.

Top module: `eeaddr_reader`

## Requirements
- R1: Chip select rises while the serial clock is low. It stays high through the command phase and all 16 data clocks, and falls only after the 16th data bit has been sampled.
- R2: Each read sends exactly 9 command bits, MSB first, on data-in. Bits [8:6] hold the read opcode 3'b110 and bits [5:0] hold the word address. The EEPROM takes each bit on a rising edge of the serial clock.
- R3: Every serial clock high time lasts HI_TICKS*TICK_DIV system cycles, and every low time inside a read lasts LO_TICKS*TICK_DIV cycles, where TICK_DIV = CLK_KHZ*TICK_NS/1000000. The low time includes the gap between chip select rising and the first clock. Data-in never changes while the serial clock is high.
- R4: After the last command bit, data-in is held low for the rest of the read. Data-out is sampled in the last system cycle of each of 16 clock-high phases and shifted in MSB first.
- R5: After the data phase, chip select drops together with the rise of a single trailing clock pulse, which has normal high and low times. A read therefore makes exactly 26 clock pulses, and a full request makes 78.
- R6: A request reads the words at addresses ADDR_LO, ADDR_MID and ADDR_HI, in that order, with no other read in between.
- R7: On completion, station_addr[47:40] is the high byte of the high word and [39:32] its low byte. [31:24] and [23:16] are the high and low bytes of the middle word, and [15:8] and [7:0] those of the low word. addr_valid pulses for exactly one cycle in the same cycle that station_addr is updated.
- R8: busy goes high in the cycle after an accepted request and falls in the cycle in which addr_valid pulses. A req asserted while busy is high is dropped: it is neither queued nor does it start another read.
- R9: During reset, ee_cs, ee_sk, ee_di, busy, addr_valid and station_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start reading the station address |
| busy | output | 1 | Read sequence in progress |
| addr_valid | output | 1 | One-cycle pulse when station_addr is updated |
| station_addr | output | 48 | Assembled station address, byte 0 at [47:40] |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with CLK_KHZ=125000 and TICK_NS=24, which gives a divider of 3. It uses HI_TICKS=3 and LO_TICKS=2, so the clock high time (9 cycles) and low time (6 cycles) differ and can each be measured exactly. A whole three-word request then fits in about 1200 cycles, so many transactions can run. The word addresses are set to 0x12, 0x13 and 0x14, which makes both the address bits and their order visible in every command frame captured by the EEPROM model.

// File: rtl/eeaddr_pkg.sv
package eeaddr_pkg;
  localparam int OP_W    = 3;
  localparam int WADDR_W = 6;
  localparam int CMD_W   = OP_W + WADDR_W;
  localparam int WORD_W  = 16;
  localparam int SADDR_W = 3 * WORD_W;

  typedef enum logic [2:0] {
    WS_IDLE, WS_PRE, WS_CMD_H, WS_CMD_L, WS_DAT_H, WS_DAT_L, WS_END_H, WS_END_L
  } wstate_t;

  typedef enum logic [1:0] {T_IDLE, T_KICK, T_WAIT} tstate_t;

  // Command frame: opcode in the top bits, word address below, sent MSB first.
  function automatic logic [CMD_W-1:0] make_cmd(input logic [OP_W-1:0] op,
                                                input logic [WADDR_W-1:0] a);
    return {op, a};
  endfunction

  // Byte 0 of the station address is the high byte of the high word; byte 5
  // is the low byte of the low word. Byte 0 sits in the top bits.
  function automatic logic [SADDR_W-1:0] assemble_addr(input logic [WORD_W-1:0] lo,
                                                       input logic [WORD_W-1:0] mid,
                                                       input logic [WORD_W-1:0] hi);
    return {hi[15:8], hi[7:0], mid[15:8], mid[7:0], lo[15:8], lo[7:0]};
  endfunction

  function automatic int tick_div(input int clk_khz, input int tick_ns);
    int d;
    d = (clk_khz * tick_ns) / 1000000;
    return (d < 1) ? 1 : d;
  endfunction
endpackage

// File: rtl/eerd_tick.sv
module eerd_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  // R3: the divider never runs past its terminal count
  p_tick_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DIV - 1));
endmodule

// File: rtl/eerd_word.sv
module eerd_word
  import eeaddr_pkg::*;
#(
  parameter int              TICK_DIV = 125,
  parameter int              HI_TICKS = 3,
  parameter int              LO_TICKS = 2,
  parameter logic [OP_W-1:0] READ_OP  = 3'b110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WADDR_W-1:0] addr,
  output logic               idle,
  output logic               done,
  output logic [WORD_W-1:0]  word,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  input  logic               ee_do
);
  localparam int PMAX = (HI_TICKS > LO_TICKS) ? HI_TICKS : LO_TICKS;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int CLW  = $clog2(CMD_W + 1);
  localparam int DLW  = $clog2(WORD_W + 1);

  wstate_t           st;
  logic [PW-1:0]     ph_cnt;
  logic [CMD_W-1:0]  cmd_sr;
  logic [CLW-1:0]    cmd_left;
  logic [WORD_W-1:0] dat_sr;
  logic [DLW-1:0]    dat_left;
  logic [DLW-1:0]    samp_cnt;
  logic              tick, accept, sk_phase, phase_end;
  logic [PW-1:0]     phase_last;

  assign idle     = (st == WS_IDLE);
  assign accept   = idle && start;
  assign sk_phase = (st == WS_CMD_H) || (st == WS_DAT_H) || (st == WS_END_H);
  assign phase_last = sk_phase ? PW'(HI_TICKS - 1) : PW'(LO_TICKS - 1);
  assign phase_end  = tick && (ph_cnt == phase_last);

  assign ee_sk = sk_phase;
  assign ee_cs = (st == WS_PRE) || (st == WS_CMD_H) || (st == WS_CMD_L) ||
                 (st == WS_DAT_H) || (st == WS_DAT_L);
  assign ee_di = ((st == WS_PRE) || (st == WS_CMD_H) || (st == WS_CMD_L)) && cmd_sr[CMD_W-1];

  eerd_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= WS_IDLE;
      ph_cnt   <= '0;
      cmd_sr   <= '0;
      cmd_left <= '0;
      dat_sr   <= '0;
      dat_left <= '0;
      samp_cnt <= '0;
      done     <= 1'b0;
      word     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st       <= WS_PRE;
        ph_cnt   <= '0;
        cmd_sr   <= make_cmd(READ_OP, addr);
        cmd_left <= CLW'(CMD_W);
        samp_cnt <= '0;
      end else if (!idle && tick) begin
        if (!phase_end) begin
          ph_cnt <= ph_cnt + 1'b1;
        end else begin
          ph_cnt <= '0;
          unique case (st)
            WS_PRE:   st <= WS_CMD_H;
            WS_CMD_H: begin
              st       <= WS_CMD_L;
              cmd_sr   <= cmd_sr << 1;   // next bit appears as the clock falls
              cmd_left <= cmd_left - 1'b1;
            end
            WS_CMD_L: begin
              st       <= (cmd_left == '0) ? WS_DAT_H : WS_CMD_H;
              dat_left <= DLW'(WORD_W);
            end
            WS_DAT_H: begin
              st       <= WS_DAT_L;
              dat_sr   <= {dat_sr[WORD_W-2:0], ee_do};
              dat_left <= dat_left - 1'b1;
              samp_cnt <= samp_cnt + 1'b1;
            end
            WS_DAT_L: st <= (dat_left == '0) ? WS_END_H : WS_DAT_H;
            WS_END_H: st <= WS_END_L;
            WS_END_L: begin
              st   <= WS_IDLE;
              done <= 1'b1;
              word <= dat_sr;
            end
            default:  st <= WS_IDLE;
          endcase
        end
      end
    end
  end

  // R1: chip select comes up with the clock low
  p_cs_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> !ee_sk);
  // R1: chip select falls only after all data bits were taken
  p_cs_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (samp_cnt == DLW'(WORD_W)));
  // R3: data-in stays put while the clock is high
  p_di_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  // R4: once the command is out, data-in is quiet
  p_di_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs && cmd_left == '0) |-> !ee_di);
  // R5: a clock rising without chip select is the trailing pulse
  p_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ee_sk) && !ee_cs) |-> $fell(ee_cs));
endmodule

// File: rtl/eeaddr_reader.sv
module eeaddr_reader
  import eeaddr_pkg::*;
#(
  parameter int                 CLK_KHZ  = 125000,
  parameter int                 TICK_NS  = 1000,
  parameter int                 HI_TICKS = 3,
  parameter int                 LO_TICKS = 2,
  parameter logic [WADDR_W-1:0] ADDR_LO  = 6'd0,
  parameter logic [WADDR_W-1:0] ADDR_MID = 6'd1,
  parameter logic [WADDR_W-1:0] ADDR_HI  = 6'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  output logic               busy,
  output logic               addr_valid,
  output logic [SADDR_W-1:0] station_addr,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  input  logic               ee_do
);
  localparam int TICK_DIV = tick_div(CLK_KHZ, TICK_NS);

  tstate_t            ts;
  logic [1:0]         idx;
  logic [WORD_W-1:0]  w_lo, w_mid, rd_word;
  logic               rd_start, rd_done, rd_idle;
  logic [WADDR_W-1:0] rd_addr;

  function automatic logic [WADDR_W-1:0] pick_addr(input logic [1:0] i);
    case (i)
      2'd0:    return ADDR_LO;
      2'd1:    return ADDR_MID;
      default: return ADDR_HI;
    endcase
  endfunction

  assign busy     = (ts != T_IDLE);
  assign rd_start = (ts == T_KICK);
  assign rd_addr  = pick_addr(idx);

  eerd_word #(
    .TICK_DIV(TICK_DIV), .HI_TICKS(HI_TICKS), .LO_TICKS(LO_TICKS), .READ_OP(3'b110)
  ) u_word (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .addr(rd_addr),
    .idle(rd_idle), .done(rd_done), .word(rd_word),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts           <= T_IDLE;
      idx          <= '0;
      w_lo         <= '0;
      w_mid        <= '0;
      addr_valid   <= 1'b0;
      station_addr <= '0;
    end else begin
      addr_valid <= 1'b0;
      unique case (ts)
        T_IDLE: if (req) begin
          idx <= '0;
          ts  <= T_KICK;
        end
        T_KICK: ts <= T_WAIT;
        T_WAIT: if (rd_done) begin
          if (idx == 2'd2) begin
            station_addr <= assemble_addr(w_lo, w_mid, rd_word);
            addr_valid   <= 1'b1;
            ts           <= T_IDLE;
          end else begin
            if (idx == 2'd0) w_lo  <= rd_word;
            else             w_mid <= rd_word;
            idx <= idx + 1'b1;
            ts  <= T_KICK;
          end
        end
        default: ts <= T_IDLE;
      endcase
    end
  end

  // R8: busy only rises in answer to a request
  p_busy_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));
  // R8: the result is never flagged while the sequence still runs
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !busy);
  // R6: a word read is only launched when the reader is free
  p_one_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> rd_idle);
endmodule

// File: tb/sim_eeaddr_reader.sv
module sim_eeaddr_reader;
  localparam int HI = 3, LO = 2, DIV = 3;
  localparam logic [5:0] A_LO = 6'h12, A_MID = 6'h13, A_HI = 6'h14;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic busy, addr_valid, ee_cs, ee_sk, ee_di;
  logic ee_do = 1'b0;
  logic [47:0] station_addr;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #4 clk = ~clk;

  eeaddr_reader #(
    .CLK_KHZ(125000), .TICK_NS(24), .HI_TICKS(HI), .LO_TICKS(LO),
    .ADDR_LO(A_LO), .ADDR_MID(A_MID), .ADDR_HI(A_HI)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .addr_valid(addr_valid),
    .station_addr(station_addr), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  // ---------------- EEPROM model ----------------
  logic [15:0] mem [64];
  logic [8:0]  fr_cmd;
  logic [5:0]  cur, seen [3];
  int fr_bits, dbit, n_frames, pulses, tails, op_bad, cs_bad, dat_di_bad;

  always @(posedge ee_cs) begin
    fr_bits = 0; fr_cmd = '0; dbit = 0;
  end

  always @(negedge ee_cs) begin
    if (dbit != 16) cs_bad++;
  end

  always @(posedge ee_sk) begin
    pulses++;
    if (!ee_cs) tails++;
    else if (fr_bits < 9) begin
      fr_cmd = {fr_cmd[7:0], ee_di};
      fr_bits++;
      if (fr_bits == 9) begin
        if (fr_cmd[8:6] != 3'b110) op_bad++;
        if (n_frames < 3) seen[n_frames] = fr_cmd[5:0];
        cur = fr_cmd[5:0];
        n_frames++;
      end
    end else begin
      if (ee_di) dat_di_bad++;
      if (dbit < 16) ee_do = mem[cur][15 - dbit];
      dbit++;
    end
  end

  // ---------------- pin timing monitor ----------------
  logic p_sk = 1'b0, p_cs = 1'b0, p_di = 1'b0;
  int run = 0, run_ok = 0, tim_bad = 0, di_bad = 0, vcount = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (addr_valid) vcount++;
      if (ee_sk && p_sk && ee_di != p_di) di_bad++;
      if (ee_sk != p_sk) begin
        if (run_ok != 0) begin
          if (p_sk && run != HI * DIV) tim_bad++;
          if (!p_sk && run != LO * DIV) tim_bad++;
        end
        run = 1; run_ok = 1;
      end else run++;
      if (ee_cs && !p_cs) begin run = 1; run_ok = 1; end
    end
    p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_addr(input logic [15:0] lo, input logic [15:0] mid,
                                           input logic [15:0] hi);
    logic [7:0] b [6];
    b[5] = lo[7:0];  b[4] = lo[15:8];
    b[3] = mid[7:0]; b[2] = mid[15:8];
    b[1] = hi[7:0];  b[0] = hi[15:8];
    return {b[0], b[1], b[2], b[3], b[4], b[5]};
  endfunction

  task automatic run_txn(input logic [15:0] lo, input logic [15:0] mid,
                         input logic [15:0] hi, input bit poke);
    int w;
    mem[A_LO] = lo; mem[A_MID] = mid; mem[A_HI] = hi;
    n_frames = 0; pulses = 0; tails = 0; op_bad = 0; cs_bad = 0; dat_di_bad = 0;
    tim_bad = 0; di_bad = 0; vcount = 0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b1, "R8 busy after request", 64'(busy), 64'd1);
    if (poke) begin
      repeat (200) @(negedge clk);
      req = 1'b1;
      @(negedge clk); req = 1'b0;
    end
    w = 0;
    while (!addr_valid && w < 5000) begin @(negedge clk); w++; end
    chk(addr_valid == 1'b1, "R8 completion seen", 64'(addr_valid), 64'd1);
    chk(station_addr == exp_addr(lo, mid, hi), "R7 station address",
        64'(station_addr), 64'(exp_addr(lo, mid, hi)));
    chk(busy == 1'b0, "R8 busy low at valid", 64'(busy), 64'd0);
    repeat (60) @(negedge clk);
    chk(vcount == 1, "R7 single valid pulse (R8 busy request dropped)", 64'(vcount), 64'd1);
    chk(busy == 1'b0, "R8 no queued request", 64'(busy), 64'd0);
    chk(n_frames == 3, "R6 frame count", 64'(n_frames), 64'd3);
    chk(seen[0] == A_LO && seen[1] == A_MID && seen[2] == A_HI, "R6 word order",
        {40'd0, seen[0], seen[1], seen[2]}, {40'd0, A_LO, A_MID, A_HI});
    chk(op_bad == 0, "R2 read opcode", 64'(op_bad), 64'd0);
    chk(pulses == 78, "R5 pulse count", 64'(pulses), 64'd78);
    chk(tails == 3, "R5 trailing pulses", 64'(tails), 64'd3);
    chk(tim_bad == 0, "R3 clock high/low widths", 64'(tim_bad), 64'd0);
    chk(di_bad == 0, "R3 data-in stable while high", 64'(di_bad), 64'd0);
    chk(dat_di_bad == 0, "R4 data-in low in data phase", 64'(dat_di_bad), 64'd0);
    chk(cs_bad == 0, "R1 chip select held for all data", 64'(cs_bad), 64'd0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd5021));
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    n_frames = 0;
    repeat (4) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, busy, addr_valid} == 5'b0, "R9 pins and flags in reset",
        64'({ee_cs, ee_sk, ee_di, busy, addr_valid}), 64'd0);
    chk(station_addr == 48'd0, "R9 address in reset", 64'(station_addr), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && ee_cs == 1'b0, "R9 idle after reset", 64'({busy, ee_cs}), 64'd0);
    // directed corners
    run_txn(16'hA000, 16'hC900, 16'h0000, 1'b0);
    run_txn(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
    run_txn(16'h0000, 16'h0000, 16'h0000, 1'b0);
    run_txn(16'h5AA5, 16'h0102, 16'h8001, 1'b1);
    // random words, some with a request during busy
    for (int k = 0; k < 6; k++)
      run_txn(16'($urandom), 16'($urandom), 16'($urandom), bit'(k % 2));
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule